// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a video output path. A horizontal counter steps once per pixel clock and wraps at a programmed total. A vertical counter steps at each line wrap and wraps at its own total. The block compares both counters against programmed windows to form the horizontal and vertical sync pulses, the active-picture enable and a frame-start marker. All boundaries are absolute counter values, not porch widths. One input inverts both sync outputs, for monitors that expect negative-going sync.

For scaled low-resolution modes, the block issues a pixel-advance strobe only once every N active pixels, and a line-advance strobe only once every M active lines. The memory fetch logic then repeats each pixel N times and each line M times. N is the programmed horizontal repeat multiplied by a factor that the pixel format selects, because narrow formats pack several pixels into each fetched word.

Software writes a complete timing set in one strobe. The set is held as pending and takes effect at the next frame boundary, so a frame is never shown with mixed geometry. A resync request restarts the raster at the origin. A resync also applies the pending set at once.

Top module: `raster_timer`

## Requirements
- R1: `hCount` counts up by one per clock from 0 to hTotal-1 and then returns to 0.
- R2: `vCount` increments in the cycle after `hCount` reaches hTotal-1. It returns to 0 after the line with `vCount` = vTotal-1, and it stays below vTotal.
- R3: `hSync` equals (hSyncBeg ≤ `hCount` < hSyncEnd) XOR the sync-invert bit.
- R4: `vSync` equals (vSyncBeg ≤ `vCount` < vSyncEnd) XOR the same sync-invert bit.
- R5: `activeEn` is high only when `hCount` < width and `vCount` < height.
- R6: `frameStart` is high exactly when both counters are 0.
- R7: A set written with `cfgWrite` becomes active in the cycle after the end of the current frame (hCount = hTotal-1 and vCount = vTotal-1). Until then the previous set governs every output. A write in the same cycle as a frame end or resync is held pending for the following boundary.
- R8: `resyncReq` sets both counters to 0 at the next edge and overrides normal counting. It also applies the pending set.
- R9: `pixAdvance` is high on active cycles where `hCount` mod D = D-1. D = hRepeat × 1 for format code 0, × 2 for code 1, × 4 for code 2, and × 1 for code 3.
- R10: `lineAdvance` is high in the cycle with `hCount` = hTotal-1, on rows with `vCount` < height and `vCount` mod vRepeat = vRepeat-1.
- R11: After reset both counters are 0 and the active set is the 800×525 total, 640×480 picture timing: hsync 656–752, vsync 490–492, no inversion, repeats 1, format 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Capture all cfg* inputs into the pending set |
| cfgHTotal | input | 12 | Clocks per line |
| cfgVTotal | input | 12 | Lines per frame |
| cfgHSyncBeg | input | 12 | First hCount with hsync asserted |
| cfgHSyncEnd | input | 12 | First hCount after hsync |
| cfgVSyncBeg | input | 12 | First vCount with vsync asserted |
| cfgVSyncEnd | input | 12 | First vCount after vsync |
| cfgWidth | input | 12 | Active pixels per line |
| cfgHeight | input | 12 | Active lines per frame |
| cfgHRepeat | input | 3 | Horizontal repeat count (1 or more) |
| cfgVRepeat | input | 3 | Vertical repeat count (1 or more) |
| cfgFormat | input | 2 | Pixel format code scaling the horizontal repeat |
| cfgSyncInvert | input | 1 | Invert both sync outputs |
| resyncReq | input | 1 | Restart raster at origin |
| hCount | output | 12 | Horizontal position |
| vCount | output | 12 | Vertical position |
| activeEn | output | 1 | Inside the picture window |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| frameStart | output | 1 | Raster at origin |
| pixAdvance | output | 1 | Fetch next pixel |
| lineAdvance | output | 1 | Fetch next line |

## Verification
Three events can fall on the same edge: a resync request, the natural end of a frame, and a write of a new timing set. The bench runs the model up to the last cycle of a frame. It then raises `resyncReq` and `cfgWrite` together. After that edge it expects the counters at the origin under the old pending set, with the freshly written set held back for the next boundary. The same coincidences also arise in the long random run and are judged cycle by cycle against the bench's own raster model.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int CNT_W = 12;
  parameter int REP_W = 3;
  parameter int FMT_W = 2;
  localparam int DIV_W = REP_W + 2;

  typedef struct packed {
    logic [CNT_W-1:0] hTotal;
    logic [CNT_W-1:0] vTotal;
    logic [CNT_W-1:0] hSyncBeg;
    logic [CNT_W-1:0] hSyncEnd;
    logic [CNT_W-1:0] vSyncBeg;
    logic [CNT_W-1:0] vSyncEnd;
    logic [CNT_W-1:0] actWidth;
    logic [CNT_W-1:0] actHeight;
    logic [REP_W-1:0] hRepeat;
    logic [REP_W-1:0] vRepeat;
    logic [FMT_W-1:0] pixFormat;
    logic             syncInvert;
  } timingCfg_t;

  // strobes from sequencing control to the counter datapath
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic restart;
  } seqStrobe_t;

  localparam timingCfg_t DEFAULT_CFG = '{
    hTotal:     CNT_W'(800),
    vTotal:     CNT_W'(525),
    hSyncBeg:   CNT_W'(656),
    hSyncEnd:   CNT_W'(752),
    vSyncBeg:   CNT_W'(490),
    vSyncEnd:   CNT_W'(492),
    actWidth:   CNT_W'(640),
    actHeight:  CNT_W'(480),
    hRepeat:    REP_W'(1),
    vRepeat:    REP_W'(1),
    pixFormat:  FMT_W'(0),
    syncInvert: 1'b0
  };
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrite,
  input  timingCfg_t       cfgIn,
  input  logic             resyncReq,
  input  logic [CNT_W-1:0] hCount,
  input  logic [CNT_W-1:0] vCount,
  output timingCfg_t       actCfg,
  output seqStrobe_t       strb
);
  timingCfg_t pendCfg;
  logic       applyCfg;

  always_comb begin
    strb.lineEnd  = (hCount >= (actCfg.hTotal - CNT_W'(1)));
    strb.frameEnd = strb.lineEnd && (vCount >= (actCfg.vTotal - CNT_W'(1)));
    strb.restart  = resyncReq;
    applyCfg      = strb.frameEnd || resyncReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendCfg <= DEFAULT_CFG;
      actCfg  <= DEFAULT_CFG;
    end else begin
      if (applyCfg) actCfg  <= pendCfg;
      if (cfgWrite) pendCfg <= cfgIn;
    end
  end

  // active set only moves at a frame boundary or resync
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.frameEnd || strb.restart) |=> $stable(actCfg));
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  timingCfg_t       cfg,
  input  seqStrobe_t       strb,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             activeEn,
  output logic             hSync,
  output logic             vSync,
  output logic             frameStart,
  output logic             pixAdvance,
  output logic             lineAdvance
);
  logic [DIV_W-1:0] hPhase;
  logic [DIV_W-1:0] hDivLast;
  logic [REP_W-1:0] vPhase;
  logic [REP_W-1:0] vRepLast;
  logic [1:0]       fmtShift;

  always_comb begin
    case (cfg.pixFormat)
      FMT_W'(1): fmtShift = 2'd1;
      FMT_W'(2): fmtShift = 2'd2;
      default:   fmtShift = 2'd0;
    endcase
    hDivLast = (DIV_W'(cfg.hRepeat) << fmtShift) - DIV_W'(1);
    vRepLast = cfg.vRepeat - REP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.restart) begin
      hCount <= '0;
      vCount <= '0;
      hPhase <= '0;
      vPhase <= '0;
    end else if (strb.lineEnd) begin
      hCount <= '0;
      hPhase <= '0;
      if (strb.frameEnd) begin
        vCount <= '0;
        vPhase <= '0;
      end else begin
        vCount <= vCount + CNT_W'(1);
        vPhase <= (vPhase == vRepLast) ? '0 : vPhase + REP_W'(1);
      end
    end else begin
      hCount <= hCount + CNT_W'(1);
      hPhase <= (hPhase == hDivLast) ? '0 : hPhase + DIV_W'(1);
    end
  end

  always_comb begin
    hSync       = ((hCount >= cfg.hSyncBeg) && (hCount < cfg.hSyncEnd)) ^ cfg.syncInvert;
    vSync       = ((vCount >= cfg.vSyncBeg) && (vCount < cfg.vSyncEnd)) ^ cfg.syncInvert;
    activeEn    = (hCount < cfg.actWidth) && (vCount < cfg.actHeight);
    frameStart  = (hCount == '0) && (vCount == '0);
    pixAdvance  = activeEn && (hPhase == hDivLast);
    lineAdvance = strb.lineEnd && (vCount < cfg.actHeight) && (vPhase == vRepLast);
  end

  assert_h_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hCount < cfg.hTotal);
  assert_v_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vCount < cfg.vTotal);
  assert_v_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lineEnd && !strb.frameEnd && !strb.restart) |=> (vCount == $past(vCount) + CNT_W'(1)));
  assert_restart_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> (hCount == '0 && vCount == '0));
  assert_frame_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.frameEnd && !strb.restart) |=> frameStart);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrite,
  input  logic [CNT_W-1:0] cfgHTotal,
  input  logic [CNT_W-1:0] cfgVTotal,
  input  logic [CNT_W-1:0] cfgHSyncBeg,
  input  logic [CNT_W-1:0] cfgHSyncEnd,
  input  logic [CNT_W-1:0] cfgVSyncBeg,
  input  logic [CNT_W-1:0] cfgVSyncEnd,
  input  logic [CNT_W-1:0] cfgWidth,
  input  logic [CNT_W-1:0] cfgHeight,
  input  logic [REP_W-1:0] cfgHRepeat,
  input  logic [REP_W-1:0] cfgVRepeat,
  input  logic [FMT_W-1:0] cfgFormat,
  input  logic             cfgSyncInvert,
  input  logic             resyncReq,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             activeEn,
  output logic             hSync,
  output logic             vSync,
  output logic             frameStart,
  output logic             pixAdvance,
  output logic             lineAdvance
);
  timingCfg_t cfgIn;
  timingCfg_t actCfg;
  seqStrobe_t strb;

  always_comb begin
    cfgIn.hTotal     = cfgHTotal;
    cfgIn.vTotal     = cfgVTotal;
    cfgIn.hSyncBeg   = cfgHSyncBeg;
    cfgIn.hSyncEnd   = cfgHSyncEnd;
    cfgIn.vSyncBeg   = cfgVSyncBeg;
    cfgIn.vSyncEnd   = cfgVSyncEnd;
    cfgIn.actWidth   = cfgWidth;
    cfgIn.actHeight  = cfgHeight;
    cfgIn.hRepeat    = cfgHRepeat;
    cfgIn.vRepeat    = cfgVRepeat;
    cfgIn.pixFormat  = cfgFormat;
    cfgIn.syncInvert = cfgSyncInvert;
  end

  raster_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgIn(cfgIn),
    .resyncReq(resyncReq), .hCount(hCount), .vCount(vCount),
    .actCfg(actCfg), .strb(strb)
  );

  raster_datapath uPath (
    .clk(clk), .rst_n(rst_n), .cfg(actCfg), .strb(strb),
    .hCount(hCount), .vCount(vCount), .activeEn(activeEn),
    .hSync(hSync), .vSync(vSync), .frameStart(frameStart),
    .pixAdvance(pixAdvance), .lineAdvance(lineAdvance)
  );
endmodule

// File: tb/tb_raster_timer.sv
`timescale 1ns/1ps
module tb_raster_timer;
  import raster_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfgWrite, resyncReq;
  timingCfg_t cfgIn;
  logic [CNT_W-1:0] hCount, vCount;
  logic activeEn, hSync, vSync, frameStart, pixAdvance, lineAdvance;

  raster_timer dut (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite),
    .cfgHTotal(cfgIn.hTotal), .cfgVTotal(cfgIn.vTotal),
    .cfgHSyncBeg(cfgIn.hSyncBeg), .cfgHSyncEnd(cfgIn.hSyncEnd),
    .cfgVSyncBeg(cfgIn.vSyncBeg), .cfgVSyncEnd(cfgIn.vSyncEnd),
    .cfgWidth(cfgIn.actWidth), .cfgHeight(cfgIn.actHeight),
    .cfgHRepeat(cfgIn.hRepeat), .cfgVRepeat(cfgIn.vRepeat),
    .cfgFormat(cfgIn.pixFormat), .cfgSyncInvert(cfgIn.syncInvert),
    .resyncReq(resyncReq), .hCount(hCount), .vCount(vCount),
    .activeEn(activeEn), .hSync(hSync), .vSync(vSync),
    .frameStart(frameStart), .pixAdvance(pixAdvance), .lineAdvance(lineAdvance)
  );

  int nChk = 0, nBad = 0;
  string ctx = "init";
  bit finished = 0;
  timingCfg_t mAct, mPend;
  int hM, vM;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s (%s) h=%0d v=%0d: got %0d expected %0d", req, ctx, hM, vM, act, exp);
    end
  endtask

  function automatic int divOf(timingCfg_t c);
    case (int'(c.pixFormat))
      1: return int'(c.hRepeat) * 2;
      2: return int'(c.hRepeat) * 4;
      default: return int'(c.hRepeat);
    endcase
  endfunction

  function automatic timingCfg_t randCfg();
    timingCfg_t c;
    int hT, vT, a, b;
    hT = 8 + int'($urandom % 33);
    vT = 5 + int'($urandom % 16);
    c.hTotal = CNT_W'(hT);
    c.vTotal = CNT_W'(vT);
    a = int'($urandom % hT); b = a + int'($urandom % (hT - a + 1));
    c.hSyncBeg = CNT_W'(a); c.hSyncEnd = CNT_W'(b);
    a = int'($urandom % vT); b = a + int'($urandom % (vT - a + 1));
    c.vSyncBeg = CNT_W'(a); c.vSyncEnd = CNT_W'(b);
    c.actWidth   = CNT_W'(1 + int'($urandom % hT));
    c.actHeight  = CNT_W'(1 + int'($urandom % vT));
    c.hRepeat    = REP_W'(1 + int'($urandom % 3));
    c.vRepeat    = REP_W'(1 + int'($urandom % 3));
    c.pixFormat  = FMT_W'($urandom % 4);
    c.syncInvert = 1'($urandom % 2);
    return c;
  endfunction

  task automatic compare();
    int hd, vr;
    bit act, le;
    hd  = divOf(mAct);
    vr  = int'(mAct.vRepeat);
    act = (hM < int'(mAct.actWidth)) && (vM < int'(mAct.actHeight));
    le  = (hM == int'(mAct.hTotal) - 1);
    chk("R1", int'(hCount), hM);
    chk("R2", int'(vCount), vM);
    chk("R3", int'(hSync), int'((hM >= int'(mAct.hSyncBeg) && hM < int'(mAct.hSyncEnd)) ^ mAct.syncInvert));
    chk("R4", int'(vSync), int'((vM >= int'(mAct.vSyncBeg) && vM < int'(mAct.vSyncEnd)) ^ mAct.syncInvert));
    chk("R5", int'(activeEn), int'(act));
    chk("R6", int'(frameStart), int'(hM == 0 && vM == 0));
    chk("R9", int'(pixAdvance), int'(act && (hM % hd == hd - 1)));
    chk("R10", int'(lineAdvance), int'(le && vM < int'(mAct.actHeight) && (vM % vr == vr - 1)));
  endtask

  // drive inputs for the coming edge and move the model across it
  task automatic advance(bit wr, timingCfg_t c, bit rs);
    bit le, fe;
    timingCfg_t nAct;
    cfgWrite = wr; cfgIn = c; resyncReq = rs;
    le = (hM == int'(mAct.hTotal) - 1);
    fe = le && (vM == int'(mAct.vTotal) - 1);
    nAct = mAct;
    if (rs || fe) nAct = mPend;
    if (wr) mPend = c;
    if (rs) begin hM = 0; vM = 0; end
    else if (le) begin hM = 0; vM = fe ? 0 : vM + 1; end
    else hM = hM + 1;
    mAct = nAct;
  endtask

  task automatic cycle(bit wr, timingCfg_t c, bit rs);
    @(negedge clk);
    compare();
    advance(wr, c, rs);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, cfgIn, 1'b0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired in %s", ctx);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    timingCfg_t c1, c2, c3;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfgWrite = 1'b0; resyncReq = 1'b0; cfgIn = DEFAULT_CFG;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mAct = DEFAULT_CFG; mPend = DEFAULT_CFG; hM = 0; vM = 0;
    ctx = "R11 reset state";
    compare();
    advance(1'b0, cfgIn, 1'b0);
    idle(20);

    // small geometry, applied through resync
    ctx = "R8 resync applies pending";
    c1 = randCfg();
    c1.pixFormat = FMT_W'(2); c1.hRepeat = REP_W'(2); c1.vRepeat = REP_W'(2);
    cycle(1'b1, c1, 1'b0);
    cycle(1'b0, c1, 1'b1);
    idle(3 * int'(c1.hTotal) * int'(c1.vTotal));

    // mid-frame write must wait for the frame end
    ctx = "R7 deferred apply";
    while (hM != 3) cycle(1'b0, cfgIn, 1'b0);
    c2 = randCfg();
    c2.pixFormat = FMT_W'(1); c2.hRepeat = REP_W'(3);
    cycle(1'b1, c2, 1'b0);
    idle(3 * int'(c1.hTotal) * int'(c1.vTotal) + 10);

    // resync, frame end and write on the same edge
    ctx = "R8 R7 coincident";
    while (!(hM == int'(mAct.hTotal) - 1 && vM == int'(mAct.vTotal) - 1))
      cycle(1'b0, cfgIn, 1'b0);
    c3 = randCfg();
    cycle(1'b1, c3, 1'b1);
    idle(2 * int'(c3.hTotal) * int'(c3.vTotal) + 50);

    // mid-line resync
    ctx = "R8 mid-line";
    while (hM != 2) cycle(1'b0, cfgIn, 1'b0);
    cycle(1'b0, cfgIn, 1'b1);
    idle(100);

    ctx = "R9 R10 random";
    for (int i = 0; i < 40000; i++) begin
      bit wr, rs;
      wr = ($urandom % 300) == 0;
      rs = ($urandom % 700) == 0;
      cycle(wr, wr ? randCfg() : cfgIn, rs);
    end
    @(negedge clk);
    compare();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule